// File: doc/BRIEF.md
# Stereo Ramped Gain Stage

This block applies a linear digital gain to a stereo audio stream, one gain per channel. Every incoming signed sample is multiplied by an unsigned gain word and the upper half of the product is returned as the scaled sample. A gain is never applied as a sudden jump in its high-order part. A new request is held in a per-channel request register. From the next sample strobe on, the coarse (upper) portion of the applied gain walks toward the requested coarse value by one code per sample. The fine (lower) portion is taken over at once. This keeps large level changes free of audible clicks.

A mute request is the OR of a pin-level mute and a control-level mute. It reuses the same walk with a target of zero for both channels. When mute is dropped, each channel walks back to whatever its request register holds at that time, including a value written while muted. The two channels are fully independent. Each has its own request register and its own walk.

Top module: `vol_ramp_atten`

## Requirements
- R1: While reset is asserted and right after it is released, both scaled outputs are zero, `out_stb` is low, and both applied gains equal the all-ones code (unity).
- R2: On a cycle with `smp_stb` high, each channel's output register loads floor(sample × G / 2^GAIN_W), truncated to DATA_W bits. The sample is signed two's complement and G is the channel's applied gain after that strobe's update. The output and gain appear, with `out_stb` high, on the next cycle and are held until the next strobe.
- R3: Each strobe moves the coarse field (the upper GAIN_W−FINE_W bits) of the applied gain by exactly one code toward the coarse field of the target. The coarse field holds when the two are equal. Without a strobe the applied gain does not change.
- R4: On the first strobe after a request, the fine field (the lower FINE_W bits) of the applied gain equals the fine field of the target.
- R5: A request write (`req_wr_*` high) only loads the request register. The applied gain keeps its value until the next strobe.
- R6: When `hw_mute` or `sw_mute` is high, the target of both channels is zero. The fine field clears at the next strobe and the coarse field falls by one code per strobe down to zero, where the outputs are zero.
- R7: After mute is released, each channel's gain walks back to the value currently held in its request register, including a value written during mute.
- R8: A request or walk in one channel leaves the other channel's gain and output unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle per frame |
| smp_l_i | input | DATA_W | Left input sample, signed |
| smp_r_i | input | DATA_W | Right input sample, signed |
| req_wr_l | input | 1 | Load left request register |
| req_wr_r | input | 1 | Load right request register |
| req_gain_l | input | GAIN_W | Left requested gain |
| req_gain_r | input | GAIN_W | Right requested gain |
| hw_mute | input | 1 | Pin-level mute request |
| sw_mute | input | 1 | Control-level mute request |
| out_stb | output | 1 | Scaled samples updated this cycle |
| out_l_o | output | DATA_W | Left scaled sample |
| out_r_o | output | DATA_W | Right scaled sample |
| gain_l_o | output | GAIN_W | Left applied gain |
| gain_r_o | output | GAIN_W | Right applied gain |

## Verification
The bench builds the block with DATA_W=16, GAIN_W=8 and FINE_W=3. This leaves a 5-bit coarse field, so a full walk from unity to silence takes 31 strobes. Complete mute ramps, release ramps and long attenuation walks therefore fit in a few dozen sample frames. With the fine field at 3 bits, an immediate fine update can be told apart from a coarse step. The narrow words still leave the truncation of negative products visible on full-scale and near-zero samples.

// File: rtl/vol_pkg.sv
package vol_pkg;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/vol_req_reg.sv
module vol_req_reg #(
  parameter int unsigned GAIN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GAIN_W-1:0] wr_gain,
  output logic [GAIN_W-1:0] req_q
);

  logic [GAIN_W-1:0] req_d;

  always_comb begin
    req_d = req_q;
    if (wr_en) begin
      req_d = wr_gain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '1;
    end else begin
      req_q <= req_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(req_q)); // R5

  AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (req_q == $past(wr_gain))); // R5

endmodule

// File: rtl/vol_gain_ramp.sv
module vol_gain_ramp
  import vol_pkg::*;
#(
  parameter int unsigned GAIN_W = 14,
  parameter int unsigned FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              mute,
  input  logic [GAIN_W-1:0] req,
  output logic [GAIN_W-1:0] gain_q,
  output logic [GAIN_W-1:0] gain_nxt
);

  localparam int unsigned COARSE_W = GAIN_W - FINE_W;

  logic [GAIN_W-1:0]   tgt;
  logic [COARSE_W-1:0] cur_c;
  logic [COARSE_W-1:0] tgt_c;
  logic [COARSE_W-1:0] nxt_c;
  ramp_dir_e           dir;
  logic [GAIN_W-1:0]   gain_d;

  always_comb begin
    tgt   = mute ? '0 : req;
    cur_c = gain_q[GAIN_W-1:FINE_W];
    tgt_c = tgt[GAIN_W-1:FINE_W];
    if (cur_c < tgt_c) begin
      dir = RAMP_UP;
    end else if (cur_c > tgt_c) begin
      dir = RAMP_DOWN;
    end else begin
      dir = RAMP_HOLD;
    end
    case (dir)
      RAMP_UP:   nxt_c = cur_c + 1'b1;
      RAMP_DOWN: nxt_c = cur_c - 1'b1;
      default:   nxt_c = cur_c;
    endcase
    gain_nxt = {nxt_c, tgt[FINE_W-1:0]};
  end

  always_comb begin
    gain_d = gain_q;
    if (stb) begin
      gain_d = gain_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '1;
    end else begin
      gain_q <= gain_d;
    end
  end

  AST_RAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(gain_q)); // R3

  AST_RAMP_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !mute && (gain_q[GAIN_W-1:FINE_W] < req[GAIN_W-1:FINE_W]))
    |=> (gain_q[GAIN_W-1:FINE_W] == $past(gain_q[GAIN_W-1:FINE_W]) + 1'b1)); // R3

  AST_RAMP_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !mute && (gain_q[GAIN_W-1:FINE_W] == req[GAIN_W-1:FINE_W]))
    |=> $stable(gain_q[GAIN_W-1:FINE_W])); // R3

  AST_FINE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !mute) |=> (gain_q[FINE_W-1:0] == $past(req[FINE_W-1:0]))); // R4

  AST_MUTE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mute) |=> ((gain_q[FINE_W-1:0] == '0) &&
      ((gain_q[GAIN_W-1:FINE_W] == $past(gain_q[GAIN_W-1:FINE_W]) - 1'b1) ||
       (gain_q[GAIN_W-1:FINE_W] == '0)))); // R6

endmodule

// File: rtl/vol_scaler.sv
module vol_scaler #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] out_q
);

  localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;

  logic [PROD_W-1:0] smp_ext;
  logic [PROD_W-1:0] gain_ext;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    smp_ext  = {{(GAIN_W + 1){sample[DATA_W-1]}}, sample};
    gain_ext = {{(DATA_W + 1){1'b0}}, gain};
    out_d    = out_q;
    if (stb) begin
      out_d = DATA_W'(($signed(smp_ext) * $signed(gain_ext)) >>> GAIN_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(out_q)); // R2

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (gain == '0)) |=> (out_q == '0)); // R6

  AST_ZERO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (sample == '0)) |=> (out_q == '0)); // R2

endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten
  import vol_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned GAIN_W = 14,
  parameter int unsigned FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_l_i,
  input  logic [DATA_W-1:0] smp_r_i,
  input  logic              req_wr_l,
  input  logic              req_wr_r,
  input  logic [GAIN_W-1:0] req_gain_l,
  input  logic [GAIN_W-1:0] req_gain_r,
  input  logic              hw_mute,
  input  logic              sw_mute,
  output logic              out_stb,
  output logic [DATA_W-1:0] out_l_o,
  output logic [DATA_W-1:0] out_r_o,
  output logic [GAIN_W-1:0] gain_l_o,
  output logic [GAIN_W-1:0] gain_r_o
);

  logic                            mute_any;
  logic [NUM_CH-1:0]               wr_v;
  logic [NUM_CH-1:0][GAIN_W-1:0]   wr_gain_v;
  logic [NUM_CH-1:0][DATA_W-1:0]   smp_v;
  logic [NUM_CH-1:0][GAIN_W-1:0]   req_v;
  logic [NUM_CH-1:0][GAIN_W-1:0]   gain_v;
  logic [NUM_CH-1:0][GAIN_W-1:0]   gain_nxt_v;
  logic [NUM_CH-1:0][DATA_W-1:0]   out_v;
  logic                            out_stb_d;

  always_comb begin
    mute_any     = hw_mute | sw_mute;
    wr_v         = {req_wr_r, req_wr_l};
    wr_gain_v[0] = req_gain_l;
    wr_gain_v[1] = req_gain_r;
    smp_v[0]     = smp_l_i;
    smp_v[1]     = smp_r_i;
    out_stb_d    = smp_stb;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    vol_req_reg #(
      .GAIN_W (GAIN_W)
    ) i_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_v[ch]),
      .wr_gain (wr_gain_v[ch]),
      .req_q   (req_v[ch])
    );

    vol_gain_ramp #(
      .GAIN_W (GAIN_W),
      .FINE_W (FINE_W)
    ) i_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (smp_stb),
      .mute     (mute_any),
      .req      (req_v[ch]),
      .gain_q   (gain_v[ch]),
      .gain_nxt (gain_nxt_v[ch])
    );

    vol_scaler #(
      .DATA_W (DATA_W),
      .GAIN_W (GAIN_W)
    ) i_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (smp_stb),
      .sample (smp_v[ch]),
      .gain   (gain_nxt_v[ch]),
      .out_q  (out_v[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb <= 1'b0;
    end else begin
      out_stb <= out_stb_d;
    end
  end

  assign out_l_o  = out_v[0];
  assign out_r_o  = out_v[1];
  assign gain_l_o = gain_v[0];
  assign gain_r_o = gain_v[1];

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_stb); // R2

  AST_OUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_stb); // R2

  AST_CH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !mute_any && (gain_r_o == req_v[1])) |=> $stable(gain_r_o)); // R8

endmodule

// File: tb/test_vol_ramp_atten.sv
module test_vol_ramp_atten;
  localparam int unsigned DW = 16;
  localparam int unsigned GW = 8;
  localparam int unsigned FW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_stb;
  logic [DW-1:0] smp_l, smp_r;
  logic          req_wr_l, req_wr_r;
  logic [GW-1:0] req_gain_l, req_gain_r;
  logic          hw_mute, sw_mute;
  logic          out_stb;
  logic [DW-1:0] out_l, out_r;
  logic [GW-1:0] gain_l, gain_r;

  always #5 clk = ~clk;

  vol_ramp_atten #(.DATA_W(DW), .GAIN_W(GW), .FINE_W(FW)) i_vol_ramp_atten (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .smp_l_i(smp_l), .smp_r_i(smp_r),
    .req_wr_l(req_wr_l), .req_wr_r(req_wr_r),
    .req_gain_l(req_gain_l), .req_gain_r(req_gain_r),
    .hw_mute(hw_mute), .sw_mute(sw_mute),
    .out_stb(out_stb), .out_l_o(out_l), .out_r_o(out_r),
    .gain_l_o(gain_l), .gain_r_o(gain_r)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [DW-1:0] l;
    logic [DW-1:0] r;
    logic [GW-1:0] gl;
    logic [GW-1:0] gr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [GW-1:0] m_gl, m_gr, m_ql, m_qr;

  function automatic logic [GW-1:0] next_gain(input logic [GW-1:0] g,
                                              input logic [GW-1:0] q,
                                              input logic mt);
    logic [GW-1:0] t;
    int c, tc;
    t  = mt ? '0 : q;
    c  = int'(g >> FW);
    tc = int'(t >> FW);
    if (c < tc) c = c + 1;
    else if (c > tc) c = c - 1;
    return GW'((c << FW) | int'(t % (1 << FW)));
  endfunction

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] s, input logic [GW-1:0] g);
    longint p;
    p = longint'($signed(s)) * longint'({1'b0, g});
    p = p >>> GW;
    return p[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 4099 + 32768 + (i % 3) * 7);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_stb(input logic [DW-1:0] l, input logic [DW-1:0] r, input string tag);
    @(negedge clk);
    smp_l = l;
    smp_r = r;
    smp_stb = 1'b1;
    m_gl = next_gain(m_gl, m_ql, hw_mute | sw_mute);
    m_gr = next_gain(m_gr, m_qr, hw_mute | sw_mute);
    exp_q.push_back('{l: scale(l, m_gl), r: scale(r, m_gr), gl: m_gl, gr: m_gr});
    tag_q.push_back(tag);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic wr_req(input bit right, input logic [GW-1:0] v);
    @(negedge clk);
    if (right) begin req_wr_r = 1'b1; req_gain_r = v; m_qr = v; end
    else       begin req_wr_l = 1'b1; req_gain_l = v; m_ql = v; end
    @(negedge clk);
    req_wr_l = 1'b0;
    req_wr_r = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 actual=out_stb expected=no output");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " left out"},   64'(out_l),  64'(e.l));
        check({t, " right out"},  64'(out_r),  64'(e.r));
        check({t, " left gain"},  64'(gain_l), 64'(e.gl));
        check({t, " right gain"}, 64'(gain_r), 64'(e.gr));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0; smp_l = '0; smp_r = '0;
    req_wr_l = 1'b0; req_wr_r = 1'b0; req_gain_l = '0; req_gain_r = '0;
    hw_mute = 1'b0; sw_mute = 1'b0;
    m_gl = '1; m_gr = '1; m_ql = '1; m_qr = '1;
    repeat (3) @(negedge clk);
    smp_stb = 1'b1; smp_l = 16'h7FFF; // strobe during reset must not matter
    @(negedge clk);
    check("R1 out_l in reset", 64'(out_l), 64'(0));
    check("R1 out_r in reset", 64'(out_r), 64'(0));
    check("R1 out_stb in reset", 64'(out_stb), 64'(0));
    check("R1 gain_l in reset", 64'(gain_l), 64'(8'hFF));
    smp_stb = 1'b0; smp_l = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gain_r after reset", 64'(gain_r), 64'(8'hFF));
    check("R1 out_l after reset", 64'(out_l), 64'(0));

    // R2: unity gain on assorted samples
    do_stb(16'h7FFF, 16'h8000, "R2");
    do_stb(16'h0000, 16'hFFFF, "R2");
    do_stb(16'h0001, 16'h1234, "R2");
    for (int i = 0; i < 5; i++) do_stb(pat(i), pat(i + 11), "R2");

    // R5: write without strobe leaves gain
    wr_req(1'b0, 8'h40);
    repeat (3) @(negedge clk);
    check("R5 gain_l before strobe", 64'(gain_l), 64'(8'hFF));
    // R3: coarse walk down, right untouched (R8)
    for (int i = 0; i < 30; i++) do_stb(pat(i), pat(i + 3), "R3");
    check("R3 gain_l settled", 64'(gain_l), 64'(8'h40));
    check("R8 gain_r untouched", 64'(gain_r), 64'(8'hFF));

    // R4: fine bits only
    wr_req(1'b0, 8'h45);
    do_stb(16'h4000, 16'hC000, "R4");
    check("R4 fine immediate", 64'(gain_l), 64'(8'h45));

    // R6: pin mute
    hw_mute = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no change before strobe", 64'(gain_l), 64'(8'h45));
    for (int i = 0; i < 34; i++) do_stb(pat(i + 5), pat(i + 9), "R6");
    check("R6 gain_l muted", 64'(gain_l), 64'(0));
    check("R6 gain_r muted", 64'(gain_r), 64'(0));
    do_stb(16'h7FFF, 16'h8000, "R6");
    check("R6 muted output", 64'(out_r), 64'(0));

    // R7: release
    hw_mute = 1'b0;
    for (int i = 0; i < 34; i++) do_stb(pat(i + 2), pat(i + 8), "R7");
    check("R7 left back", 64'(gain_l), 64'(8'h45));
    check("R7 right back", 64'(gain_r), 64'(8'hFF));

    // R6/R7: control mute with request written during mute
    sw_mute = 1'b1;
    for (int i = 0; i < 10; i++) do_stb(pat(i + 20), pat(i + 30), "R6");
    wr_req(1'b1, 8'h12);
    for (int i = 0; i < 30; i++) do_stb(pat(i + 40), pat(i + 50), "R6");
    check("R6 sw mute right", 64'(gain_r), 64'(0));
    sw_mute = 1'b0;
    for (int i = 0; i < 34; i++) do_stb(pat(i + 60), pat(i + 70), "R7");
    check("R7 new request after mute", 64'(gain_r), 64'(8'h12));

    // R8: right walks up while left changes fine only
    wr_req(1'b1, 8'hC9);
    wr_req(1'b0, 8'h46);
    for (int i = 0; i < 25; i++) do_stb(pat(i + 80), pat(i + 90), "R8");
    check("R8 right walked", 64'(gain_r), 64'(8'hC9));
    check("R8 left independent", 64'(gain_l), 64'(8'h46));

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 64'(exp_q.size()), 64'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule